// File: doc/BRIEF.md
# Management Packet Routing Filter

This block picks a destination for every received frame once the frame has been fully parsed. Upstream comparators supply a vector of per-filter match flags. The block compares that vector with two masks that software configures. The first is a management enable mask. It selects which filters claim a frame for the management controller. The second is a management-to-host mask. It selects which of the claimed frames are copied to the host as well. The shared layer-2 check must pass before either mask is considered. A frame that fails the layer-2 check goes nowhere.

The block has its own comparator for the remote-management UDP port. It sets the RMCP filter flag when the frame carries UDP and the destination port is 0x298 or 0x26F. A single-cycle strobe marks the end of a frame. One cycle later the block presents a registered two-bit decision together with a valid pulse.

Top module: `mgmt_route_filter`

## Requirements
- R1: After reset, dec_vld and dec are 0 and both masks are cleared. As a result, every frame that passes the layer-2 check is decided as host only (dec = 2'b01).
- R2: dec_vld is high for exactly the one cycle after each cycle in which frame_end is high. While dec_vld is low, dec is 2'b00.
- R3: A frame whose l2_pass is low at frame_end is dropped, with dec = 2'b00. This holds whatever the flags and masks are.
- R4: If a frame passes layer 2 and none of its effective match flags is set in the management enable mask, the decision is host only: dec = 2'b01. Bit 0 of dec means host and bit 1 means management.
- R5: If a frame passes layer 2 and at least one effective match flag is set in the management enable mask, dec[1] is set. In that case dec[0] is clear unless R6 applies.
- R6: A frame routed to management whose effective match flags overlap the management-to-host mask is decided as both destinations (dec = 2'b11). The management-to-host mask has no effect on a frame that is not routed to management.
- R7: The effective match vector is match with bit 6 (RMCP) replaced by the internal port check. That bit is 1 exactly when udp_ok is high and udp_dport is 0x298 or 0x26F. The match[6] input is ignored. Bit order of the vector: 0 MAC address, 1 broadcast, 2 multicast, 3 VLAN, 4 ARP request, 5 ARP response, 6 RMCP port, 7 flexible port, 8 EtherType.
- R8: A cycle with cfg_wr high loads cfg_data into the management enable mask when cfg_sel is 0, or into the management-to-host mask when cfg_sel is 1. The new value applies to frames that end in later cycles. A frame that ends in the same cycle as the write is decided with the previous mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Mask write strobe |
| cfg_sel | input | 1 | 0: management enable mask, 1: management-to-host mask |
| cfg_data | input | 9 | Mask value to write |
| frame_end | input | 1 | End-of-frame strobe; flags below are valid in this cycle |
| l2_pass | input | 1 | Shared layer-2 check passed |
| match | input | 9 | Per-filter match flags (bit 6 ignored) |
| udp_ok | input | 1 | Frame carries a UDP header |
| udp_dport | input | 16 | UDP destination port |
| dec_vld | output | 1 | Decision valid pulse |
| dec | output | 2 | Decision: bit 0 host, bit 1 management |

## Verification
The assertions check the decision timing on every cycle. They cover the valid pulse that follows each strobe, the quiet decision between pulses, and the drop of frames that fail layer 2. They also check that a passing frame always gets a destination and that a duplicated frame always had a non-empty management-to-host mask. The exact choice among host only, management only and both depends on the mask contents and on the RMCP port comparison, so only the bench scenarios can show it. These scenarios include the ignored match[6] input, ports adjacent to the two RMCP values, and a mask write in the same cycle as a frame end.

// File: rtl/mgmt_route_filter.sv
module mgmt_route_filter #(
  parameter int NF = 9,
  parameter int RMCP_BIT = 6,
  parameter int PW = 16,
  parameter logic [PW-1:0] RMCP_PORT_A = 16'h0298,
  parameter logic [PW-1:0] RMCP_PORT_B = 16'h026F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [NF-1:0] cfg_data,
  input  logic          frame_end,
  input  logic          l2_pass,
  input  logic [NF-1:0] match,
  input  logic          udp_ok,
  input  logic [PW-1:0] udp_dport,
  output logic          dec_vld,
  output logic [1:0]    dec
);
  logic [NF-1:0] mg_en_q, m2h_q, hit_vec;
  logic [1:0] dec_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mg_en_q <= '0;
      m2h_q   <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel) m2h_q   <= cfg_data;
      else         mg_en_q <= cfg_data;
    end
  end

  wire rmcp_hit = udp_ok && (udp_dport == RMCP_PORT_A || udp_dport == RMCP_PORT_B);

  always_comb begin
    hit_vec = match;
    hit_vec[RMCP_BIT] = rmcp_hit;
  end

  wire to_mg = |(hit_vec & mg_en_q);
  wire dup   = |(hit_vec & m2h_q);

  always_comb begin
    dec_d = 2'b00;
    if (frame_end && l2_pass) dec_d = to_mg ? {1'b1, dup} : 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld <= 1'b0;
      dec     <= 2'b00;
    end else begin
      dec_vld <= frame_end;
      dec     <= dec_d;
    end
  end
endmodule

module mgmt_route_filter_chk #(
  parameter int NF = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_end,
  input logic          l2_pass,
  input logic          dec_vld,
  input logic [1:0]    dec,
  input logic [NF-1:0] m2h_q
);
  // R2
  vld_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> dec_vld);
  // R2
  vld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(frame_end));
  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> dec == 2'b00);
  // R3
  l2_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !l2_pass) |=> dec == 2'b00);
  // R4
  pass_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && l2_pass) |=> dec != 2'b00);
  // R6
  dup_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec == 2'b11) |-> $past(m2h_q) != '0);
endmodule

bind mgmt_route_filter mgmt_route_filter_chk #(.NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .l2_pass(l2_pass),
  .dec_vld(dec_vld), .dec(dec), .m2h_q(m2h_q)
);

// File: tb/test_mgmt_route_filter.sv
module test_mgmt_route_filter;
  localparam int NF = 9;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0, frame_end = 0, l2_pass = 0, udp_ok = 0;
  logic [NF-1:0] cfg_data = '0, match = '0;
  logic [15:0] udp_dport = '0;
  logic dec_vld;
  logic [1:0] dec;
  logic [NF-1:0] m_en = '0, m_dup = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mgmt_route_filter i_mgmt_route_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .frame_end(frame_end), .l2_pass(l2_pass), .match(match), .udp_ok(udp_ok),
    .udp_dport(udp_dport), .dec_vld(dec_vld), .dec(dec));

  function automatic logic [1:0] expect_dec(logic l2, logic [NF-1:0] m, logic u,
                                            logic [15:0] p, logic [NF-1:0] en,
                                            logic [NF-1:0] dp);
    logic [NF-1:0] v;
    v = m;
    v[6] = u && (p == 16'h0298 || p == 16'h026F);
    if (!l2) return 2'b00;
    if ((v & en) == '0) return 2'b01;
    return ((v & dp) != '0) ? 2'b11 : 2'b10;
  endfunction

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual vld/dec=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wr_mask(logic sel, logic [NF-1:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_wr = 0;
    if (sel) m_dup = d; else m_en = d;
  endtask

  task automatic frame(string req, logic l2, logic [NF-1:0] m, logic u, logic [15:0] p);
    logic [1:0] e;
    @(negedge clk);
    e = expect_dec(l2, m, u, p, m_en, m_dup);
    frame_end = 1; l2_pass = l2; match = m; udp_ok = u; udp_dport = p;
    @(negedge clk);
    frame_end = 0;
    chk(req, {dec_vld, dec}, {1'b1, e});
    @(negedge clk);
    chk("R2", {dec_vld, dec}, 3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", {dec_vld, dec}, 3'b000);
    frame("R1", 1, 9'h1FF, 1, 16'h0298);
    frame("R3", 0, 9'h1FF, 1, 16'h0298);
    wr_mask(0, 9'b0_0000_0010);
    frame("R5", 1, 9'b0_0000_0010, 0, 0);
    frame("R4", 1, 9'b1_1111_1101, 0, 0);
    wr_mask(1, 9'b0_0000_0010);
    frame("R6", 1, 9'b0_0000_0010, 0, 0);
    frame("R6", 1, 9'b0_0000_0100, 0, 0);
    wr_mask(0, 9'b0_0100_0000);
    wr_mask(1, 9'h000);
    frame("R7", 1, 9'h000, 1, 16'h0298);
    frame("R7", 1, 9'h000, 1, 16'h026F);
    frame("R7", 1, 9'h040, 1, 16'h0299);
    frame("R7", 1, 9'h000, 1, 16'h026E);
    frame("R7", 1, 9'h000, 0, 16'h0298);
    frame("R3", 0, 9'h000, 1, 16'h0298);
    // R8: write in the same cycle as the frame end uses the old mask
    @(negedge clk);
    frame_end = 1; l2_pass = 1; match = 9'h001; udp_ok = 0; udp_dport = 0;
    cfg_wr = 1; cfg_sel = 0; cfg_data = 9'h001;
    @(negedge clk);
    frame_end = 0; cfg_wr = 0;
    chk("R8", {dec_vld, dec}, 3'b101);
    m_en = 9'h001;
    frame("R8", 1, 9'h001, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] p;
      if ($urandom_range(0, 9) == 0) wr_mask($urandom_range(0, 1), NF'($urandom()));
      case ($urandom_range(0, 3))
        0: p = 16'h0298;
        1: p = 16'h026F;
        2: p = 16'h0298 + 16'($urandom_range(1, 2));
        default: p = 16'($urandom());
      endcase
      frame("R5", $urandom_range(0, 7) != 0, NF'($urandom()), $urandom_range(0, 1), p);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule